// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Port

This block holds the two threshold values used by a FIFO's programmable almost-empty and almost-full flags, and gives software-free access to them over the FIFO's own data buses. A single active-low load input turns the FIFO's write and read enables into register accesses. While load is low, each qualified write-clock edge stores the data bus into one of the two offsets. Successive accesses alternate: almost-empty first, then almost-full, then almost-empty again. Qualified read-clock edges return the offsets on the readback word in the same alternation. The write side and the read side each keep their own position in the alternation.

A session may touch just one or two registers before load returns high. The position is kept while load is high, so the next session carries on from where the previous one stopped. With load high, the enables are passed on as decoded FIFO write and read strobes. The current offsets go to the flag comparators continuously.

Top module: `flag_offset_regs`

## Requirements
- R1: After reset, both offsets read 127, both sequence positions select the almost-empty register, and the readback word is zero.
- R2: With load_ni low and wen_ni low, each write-clock rising edge stores data_i[15:0] into the selected offset. Stores alternate almost-empty, almost-full, almost-empty, and so on, and leave the other offset unchanged.
- R3: Both offsets are unchanged across a write-clock edge when load_ni is high or wen_ni is high.
- R4: fifo_wr_o is 1 exactly when load_ni is 1 and wen_ni is 0. fifo_rd_o is 1 exactly when load_ni is 1 and ren_ni is 0.
- R5: With load_ni low and ren_ni low, each read-clock rising edge loads the selected offset, as its value before that edge, into rdback_o[15:0]. Reads alternate almost-empty, almost-full, almost-empty.
- R6: rdback_o[17:16] is always zero.
- R7: rdback_o holds its value across a read-clock edge when load_ni is high or ren_ni is high.
- R8: A high load_ni does not move either sequence position. Write and read positions advance independently of each other.
- R9: data_i[17:16] has no effect on the stored offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Register access select, active low |
| wen_ni | input | 1 | Write enable, active low |
| ren_ni | input | 1 | Read enable, active low |
| data_i | input | 18 | Write data bus |
| empty_off_o | output | 16 | Current almost-empty offset |
| full_off_o | output | 16 | Current almost-full offset |
| rdback_o | output | 18 | Registered offset readback word |
| fifo_wr_o | output | 1 | Decoded FIFO write strobe |
| fifo_rd_o | output | 1 | Decoded FIFO read strobe |

## Verification
The bench builds the block with its default parameters: an 18-bit bus, 16-bit offsets and a reset offset of 127. It drives both clocks from one 125 MHz source. Same-edge write and read accesses therefore occur, and the bench can check that a read returns the value from before a store made in the same cycle. Random data with nonzero upper bits checks that bits 17:16 are dropped. Long runs with load mostly low interleave write and read sessions of odd and even lengths, which exercises independent and persistent sequence positions.

// File: rtl/flag_offset_pkg.sv
package flag_offset_pkg;
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } off_sel_e;
endpackage

// File: rtl/offset_seq.sv
module offset_seq
  import flag_offset_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     step_i,
  output off_sel_e sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_o <= SEL_EMPTY;
    else if (step_i) sel_o <= (sel_o == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  end
endmodule

// File: rtl/offset_bank.sv
module offset_bank
  import flag_offset_pkg::*;
#(
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned RST_OFF = 127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  off_sel_e         sel_i,
  input  logic [OFF_W-1:0] wdata_i,
  output logic [OFF_W-1:0] empty_o,
  output logic [OFF_W-1:0] full_o
);
  localparam int unsigned NREG = 2;
  localparam logic [OFF_W-1:0] RST_VAL = OFF_W'(RST_OFF);

  logic [OFF_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= RST_VAL;
      else if (we_i && (int'(sel_i) == g))           regs_q[g] <= wdata_i;
    end
  end

  assign empty_o = regs_q[SEL_EMPTY];
  assign full_o  = regs_q[SEL_FULL];
endmodule

// File: rtl/offset_readback.sv
module offset_readback
  import flag_offset_pkg::*;
#(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  off_sel_e          sel_i,
  input  logic [OFF_W-1:0]  empty_i,
  input  logic [OFF_W-1:0]  full_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = '0;
    word_d[OFF_W-1:0] = (sel_i == SEL_FULL) ? full_i : empty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= '0;
    else if (re_i) word_o <= word_d;
  end
endmodule

// File: rtl/flag_offset_regs.sv
module flag_offset_regs
  import flag_offset_pkg::*;
#(
  parameter int unsigned DATA_W  = 18,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned RST_OFF = 127
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic              wen_ni,
  input  logic              ren_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [OFF_W-1:0]  empty_off_o,
  output logic [OFF_W-1:0]  full_off_o,
  output logic [DATA_W-1:0] rdback_o,
  output logic              fifo_wr_o,
  output logic              fifo_rd_o
);
  logic     reg_wr, reg_rd;
  off_sel_e wr_sel, rd_sel;
  logic     unused_hi;

  assign reg_wr    = !load_ni && !wen_ni;
  assign reg_rd    = !load_ni && !ren_ni;
  assign fifo_wr_o = load_ni && !wen_ni;
  assign fifo_rd_o = load_ni && !ren_ni;
  assign unused_hi = ^data_i[DATA_W-1:OFF_W];

  // offset writes are sequenced in the write domain, reads in the read domain
  offset_seq u_wr_seq (
    .clk_i (wclk_i), .rst_ni (rst_ni), .step_i (reg_wr), .sel_o (wr_sel)
  );

  offset_seq u_rd_seq (
    .clk_i (rclk_i), .rst_ni (rst_ni), .step_i (reg_rd), .sel_o (rd_sel)
  );

  offset_bank #(.OFF_W(OFF_W), .RST_OFF(RST_OFF)) u_bank (
    .clk_i   (wclk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_wr),
    .sel_i   (wr_sel),
    .wdata_i (data_i[OFF_W-1:0]),
    .empty_o (empty_off_o),
    .full_o  (full_off_o)
  );

  offset_readback #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_rdbk (
    .clk_i   (rclk_i),
    .rst_ni  (rst_ni),
    .re_i    (reg_rd),
    .sel_i   (rd_sel),
    .empty_i (empty_off_o),
    .full_i  (full_off_o),
    .word_o  (rdback_o)
  );
endmodule

// File: rtl/flag_offset_chk.sv
module flag_offset_chk
  import flag_offset_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned OFF_W  = 16
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              load_ni,
  input logic              wen_ni,
  input logic              ren_ni,
  input logic [DATA_W-1:0] data_i,
  input logic [OFF_W-1:0]  empty_off_o,
  input logic [OFF_W-1:0]  full_off_o,
  input logic [DATA_W-1:0] rdback_o,
  input off_sel_e          wr_sel,
  input off_sel_e          rd_sel
);
  a_r2_store_empty: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!load_ni && !wen_ni && wr_sel == SEL_EMPTY)
      |=> (empty_off_o == $past(data_i[OFF_W-1:0])) && $stable(full_off_o));

  a_r2_store_full: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!load_ni && !wen_ni && wr_sel == SEL_FULL)
      |=> (full_off_o == $past(data_i[OFF_W-1:0])) && $stable(empty_off_o));

  a_r2_wr_alternate: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!load_ni && !wen_ni) |=> (wr_sel != $past(wr_sel)));

  a_r3_no_store: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (load_ni || wen_ni) |=> $stable(empty_off_o) && $stable(full_off_o));

  a_r8_wr_pos_kept: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (load_ni || wen_ni) |=> $stable(wr_sel));

  a_r5_rd_alternate: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!load_ni && !ren_ni) |=> (rd_sel != $past(rd_sel)));

  a_r7_rd_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (load_ni || ren_ni) |=> $stable(rdback_o));

  a_r6_upper_zero: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rdback_o[DATA_W-1:OFF_W] == '0);
endmodule

bind flag_offset_regs flag_offset_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .wclk_i      (wclk_i),
  .rclk_i      (rclk_i),
  .rst_ni      (rst_ni),
  .load_ni     (load_ni),
  .wen_ni      (wen_ni),
  .ren_ni      (ren_ni),
  .data_i      (data_i),
  .empty_off_o (empty_off_o),
  .full_off_o  (full_off_o),
  .rdback_o    (rdback_o),
  .wr_sel      (wr_sel),
  .rd_sel      (rd_sel)
);

// File: tb/flag_offset_regs_bench.sv
module flag_offset_regs_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_ni = 1'b1, wen_ni = 1'b1, ren_ni = 1'b1;
  logic [17:0] data_i = '0;
  logic [15:0] empty_off_o, full_off_o;
  logic [17:0] rdback_o;
  logic        fifo_wr_o, fifo_rd_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_e, m_f;
  logic [17:0] m_rb;
  bit          m_wp, m_rp;

  always #4 clk = ~clk;

  flag_offset_regs u_flag_offset_regs (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni),
    .load_ni(load_ni), .wen_ni(wen_ni), .ren_ni(ren_ni), .data_i(data_i),
    .empty_off_o(empty_off_o), .full_off_o(full_off_o), .rdback_o(rdback_o),
    .fifo_wr_o(fifo_wr_o), .fifo_rd_o(fifo_rd_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_fwr(input logic ld, input logic we);
    return ld && !we;
  endfunction

  // one cycle: drive at negedge, update model at posedge, check at next negedge
  task automatic cyc(input logic ld, input logic we, input logic re, input logic [17:0] d);
    logic [15:0] e_old, f_old;
    load_ni = ld; wen_ni = we; ren_ni = re; data_i = d;
    #1;
    chk("R4 fifo_wr", 32'(fifo_wr_o), 32'(exp_fwr(ld, we)));
    chk("R4 fifo_rd", 32'(fifo_rd_o), 32'(exp_fwr(ld, re)));
    @(posedge clk);
    e_old = m_e; f_old = m_f;
    if (!ld && !we) begin
      if (m_wp) m_f = d[15:0]; else m_e = d[15:0];
      m_wp = ~m_wp;
    end
    if (!ld && !re) begin
      m_rb = {2'b00, (m_rp ? f_old : e_old)};
      m_rp = ~m_rp;
    end
    @(negedge clk);
    if (!ld && !we) begin
      chk("R2 empty_off", 32'(empty_off_o), 32'(m_e));
      chk("R2 full_off",  32'(full_off_o),  32'(m_f));
    end else begin
      chk("R3 empty_off", 32'(empty_off_o), 32'(m_e));
      chk("R3 full_off",  32'(full_off_o),  32'(m_f));
    end
    if (!ld && !re) chk("R5 rdback", 32'(rdback_o), 32'(m_rb));
    else            chk("R7 rdback", 32'(rdback_o), 32'(m_rb));
    chk("R6 rdback_hi", 32'(rdback_o[17:16]), 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    m_e = 16'd127; m_f = 16'd127; m_rb = '0; m_wp = 0; m_rp = 0;
    repeat (2) @(negedge clk);
    chk("R1 empty_off", 32'(empty_off_o), 32'd127);
    chk("R1 full_off",  32'(full_off_o),  32'd127);
    chk("R1 rdback",    32'(rdback_o),    32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: first read after reset returns the empty offset default
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R1 first read empty", 32'(rdback_o), 32'd127);
    // R9: upper data bits dropped
    cyc(1'b0, 1'b0, 1'b1, 18'h3_1234);
    chk("R9 empty_off", 32'(empty_off_o), 32'h1234);
    // R8: load high gap, next write goes to full offset
    cyc(1'b1, 1'b0, 1'b1, 18'h0_aaaa);
    cyc(1'b1, 1'b1, 1'b1, 18'h0_bbbb);
    cyc(1'b0, 1'b0, 1'b1, 18'h2_5678);
    chk("R8 full_off", 32'(full_off_o), 32'h5678);
    chk("R8 empty_kept", 32'(empty_off_o), 32'h1234);
    // R8: read position resumed at full after one earlier read
    cyc(1'b0, 1'b1, 1'b0, '0);
    chk("R8 read resumes full", 32'(rdback_o), 32'h5678);
    // R3: load low with wen high stores nothing
    cyc(1'b0, 1'b1, 1'b1, 18'h0_ffff);
    chk("R3 noop", 32'(empty_off_o), 32'h1234);
    // R5: same-edge write and read returns pre-write value
    cyc(1'b0, 1'b0, 1'b0, 18'h0_0001);
    chk("R5 same edge old", 32'(rdback_o), 32'h1234);
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 4) == 0, $urandom % 2, $urandom % 2, 18'($urandom));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule